// File: doc/BRIEF.md
# Input change interrupt detector

This block raises the interrupt request of a parallel port expander. It keeps a snapshot of the port pins, taken at each read of the input port. It pulls an active-low, open-drain request line whenever a pin set as an input no longer matches that snapshot. The request is level based. It goes away by itself when the pins return to their snapshot values. It also goes away when the host reads the input port, because that read refreshes the snapshot.

The block sits after the pin synchronizers and filters, and next to the bus decoder. It receives synchronized pin levels, the direction mask, and a single-cycle pulse from the decoder. The pulse marks the acknowledge slot of a byte read from the input port. All pins and outputs are plain control signals. There is no data stream here, so there is no valid/ready handshake and no back-pressure.

The comparison uses raw pin levels, taken before any polarity inversion. A change to the polarity setting therefore cannot cause an interrupt.

Top module: `irqd_change_detect`

## Requirements
- R1: If a pin with direction bit 1 (input) differs from the snapshot in a clock cycle without `rd_ack`, the request is asserted from the next clock edge: `irq_n` = 0 and `od_en` = 1. A rising difference and a falling difference both count.
- R2: When every input-direction pin again equals the snapshot, the request is released after the next clock edge.
- R3: On a cycle with `rd_ack` = 1, the snapshot loads the pin levels of that cycle and the request is released from the next edge. Later comparisons use the new snapshot.
- R4: A pin change that arrives in the same cycle as `rd_ack` is taken into the snapshot, so it raises no request afterwards.
- R5: Pins with direction bit 0 (output) never cause a request, whatever their level.
- R6: Changing a pin from output to input raises the request one edge later if its level differs from the snapshot.
- R7: The output is open-drain. While asserted, `od_en` = 1 and `irq_n` = 0. While released, `od_en` = 0 and `irq_n` = 1, the released level being set by the external pull-up.
- R8: While `rst_n` = 0, the request is released and the snapshot follows the pins, so no request is pending after reset.
- R9: Without `rd_ack`, the snapshot never changes. Bus traffic for other devices produces no `rd_ack`, so it leaves a pending request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | WIDTH | Synchronized raw pin levels |
| dir_in | input | WIDTH | Direction mask, 1 = input, 0 = output |
| rd_ack | input | 1 | One-cycle pulse at the acknowledge slot of an input-port read |
| irq_n | output | 1 | Interrupt level, 0 = asserted, 1 = released |
| od_en | output | 1 | Open-drain pull-down enable, 1 = pull low |

## Verification
The bench checks a change that lands in the same cycle as the read acknowledge. A design that gave comparison priority over capture would raise a request there, when that change should have been absorbed. It also checks a pin that returns to its old level with no read in between. A design that latched the request would keep `irq_n` low at that point. Pins held as outputs and then switched to inputs are checked as well. A design that ignored the mask would raise a request while the pins are outputs. A design that cleared the snapshot on the switch would miss the request that the switch should raise. Reset is applied with the pins changing while it is held. A design that loaded a fixed snapshot would assert a request as soon as reset is released.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned IRQD_WIDTH_DEFAULT = 8;

  typedef enum logic {
    OD_RELEASE = 1'b0,
    OD_PULL    = 1'b1
  } od_state_e;
endpackage

// File: rtl/irqd_snapshot.sv
module irqd_snapshot #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic             cap,
  output logic [WIDTH-1:0] snap
);
  always_ff @(posedge clk) begin
    if (!rst_n || cap) snap <= pin_lvl;
  end

  // R3: after a capture the snapshot holds the pins of the capture cycle
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (snap == $past(pin_lvl)));

  // R9: with no capture the snapshot does not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(snap));
endmodule

// File: rtl/irqd_compare.sv
module irqd_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic [WIDTH-1:0] snap,
  input  logic [WIDTH-1:0] dir_in,
  output logic             hit
);
  logic [WIDTH-1:0] diff;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign diff[i] = dir_in[i] & (pin_lvl[i] ^ snap[i]);
  end

  assign hit = |diff;
endmodule

// File: rtl/irqd_drive.sv
module irqd_drive
  import irqd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic irq_n,
  output logic od_en
);
  od_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= OD_RELEASE;
    else if (clr) st <= OD_RELEASE;
    else if (hit) st <= OD_PULL;
    else          st <= OD_RELEASE;
  end

  assign od_en = (st == OD_PULL);
  assign irq_n = (st == OD_RELEASE);

  // R7: the pin is either pulled low or released, never both or neither
  p_od_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({od_en, irq_n}) == 1);
endmodule

// File: rtl/irqd_change_detect.sv
module irqd_change_detect
  import irqd_pkg::*;
#(
  parameter int unsigned WIDTH = IRQD_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             rd_ack,
  output logic             irq_n,
  output logic             od_en
);
  logic [WIDTH-1:0] snap;
  logic             hit;

  irqd_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cap(rd_ack), .snap(snap)
  );

  irqd_compare #(.WIDTH(WIDTH)) u_cmp (
    .pin_lvl(pin_lvl), .snap(snap), .dir_in(dir_in), .hit(hit)
  );

  irqd_drive u_drv (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(rd_ack),
    .irq_n(irq_n), .od_en(od_en)
  );

  // R1: a masked-in mismatch without a read pulls the line next cycle
  p_mismatch_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ack && (((pin_lvl ^ snap) & dir_in) != '0)) |=> !irq_n);

  // R2: pins equal to the snapshot release the line next cycle
  p_match_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl == snap) |=> irq_n);

  // R3: a read acknowledge releases the line next cycle
  p_ack_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> (irq_n && !od_en));

  // R5: with every pin an output nothing is requested
  p_outputs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |=> !od_en);
endmodule

// File: tb/tb_irqd_change_detect.sv
module tb_irqd_change_detect;
  localparam int W = 8;
  localparam int NV = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_lvl = 8'hA5;
  logic [W-1:0] dir_in = 8'hFF;
  logic         rd_ack = 1'b0;
  logic         irq_n;
  logic         od_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqd_change_detect #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .rd_ack(rd_ack), .irq_n(irq_n), .od_en(od_en)
  );

  // {pins, direction, ack, expected request after the edge}
  localparam logic [17:0] VEC [NV] = '{
    {8'hA5, 8'hFF, 1'b0, 1'b0},  // 0  R8 quiet after reset
    {8'hA4, 8'hFF, 1'b0, 1'b1},  // 1  R1 falling bit0
    {8'hA5, 8'hFF, 1'b0, 1'b0},  // 2  R2 back to snapshot
    {8'hB5, 8'hFF, 1'b0, 1'b1},  // 3  R1 rising bit4
    {8'hB5, 8'hFF, 1'b0, 1'b1},  // 4  R9 held without read
    {8'hB5, 8'hFF, 1'b1, 1'b0},  // 5  R3 read clears, snapshot B5
    {8'hB5, 8'hFF, 1'b0, 1'b0},  // 6  R3 new snapshot matches
    {8'hA5, 8'hFF, 1'b0, 1'b1},  // 7  R3 differs from new snapshot
    {8'hA5, 8'hFF, 1'b0, 1'b1},  // 8  R9 held
    {8'hB5, 8'hFF, 1'b0, 1'b0},  // 9  R2 return to B5
    {8'hB5, 8'hFF, 1'b1, 1'b0},  // 10 R3 read
    {8'hC5, 8'hFF, 1'b1, 1'b0},  // 11 R4 change during ack
    {8'hC5, 8'hFF, 1'b0, 1'b0},  // 12 R4 change absorbed
    {8'hC4, 8'hFE, 1'b0, 1'b0},  // 13 R5 bit0 is output
    {8'h3A, 8'h00, 1'b0, 1'b0},  // 14 R5 all outputs
    {8'hC4, 8'h00, 1'b0, 1'b0},  // 15 R5 still outputs
    {8'hC4, 8'h01, 1'b0, 1'b1},  // 16 R6 bit0 to input, differs
    {8'hC4, 8'hFE, 1'b0, 1'b0},  // 17 R5 bit0 back to output
    {8'hC5, 8'h01, 1'b0, 1'b0}   // 18 R6 switch with matching level
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R8: reset with pins moving; line released throughout
    repeat (2) @(posedge clk);
    #1 check("R8 irq_n during reset", irq_n, 1'b1);
    check("R8 od_en during reset", od_en, 1'b0);
    @(negedge clk) pin_lvl = 8'h5A;
    @(negedge clk) pin_lvl = 8'hA5;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R8 irq_n after reset", irq_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pin_lvl = VEC[i][17:10];
      dir_in  = VEC[i][9:2];
      rd_ack  = VEC[i][1];
      @(posedge clk);
      #1;
      check($sformatf("R1 vector %0d irq_n", i), irq_n, ~VEC[i][0]);
      check($sformatf("R7 vector %0d od_en", i), od_en, VEC[i][0]);
    end

    // R9: long idle with a pending request and no read keeps it
    @(negedge clk) rd_ack = 1'b0; dir_in = 8'hFF; pin_lvl = 8'h00;
    repeat (20) @(posedge clk);
    #1 check("R9 request held over idle", irq_n, 1'b0);
    // R7: open-drain pair while asserted
    check("R7 od_en while asserted", od_en, 1'b1);

    // R3: read then change to a value differing from the new snapshot
    @(negedge clk) rd_ack = 1'b1;
    @(posedge clk);
    #1 check("R3 read releases", irq_n, 1'b1);
    @(negedge clk) rd_ack = 1'b0; pin_lvl = 8'h80;
    @(posedge clk);
    #1 check("R1 bit7 vs snapshot 00", irq_n, 1'b0);

    // R8: reset while a request is pending, pins differ from old snapshot
    @(negedge clk) rst_n = 1'b0; pin_lvl = 8'h33;
    @(posedge clk);
    #1 check("R8 reset releases", irq_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R8 snapshot taken in reset", od_en, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule